// File: doc/BRIEF.md
# Audio Sample Word Unpacker

This block takes 32-bit words from a transmit sample queue and turns each one into the fields that a serial audio subframe builder needs. For every subframe it presents a 24-bit audio slot, four per-subframe flag bits (validity, user, channel status, parity), a flag that asks the builder to compute parity itself, a 4-bit auxiliary nibble and a 4-bit preamble code. A 2-bit width code together with a pack flag selects how the word is read.

The three sample modes read a 16-, 20- or 24-bit sample from the bottom of the word and left-justify it into the slot. The raw mode carries every subframe field inside the word. The packed mode holds two 16-bit samples in one word and emits two subframes from it, left first. Both sides use a valid/ready handshake. The width code and the pack flag are captured together with each word, so changing them only affects words accepted later.

Top module: `audio_word_unpack`

## Requirements
- R1: Width code 00, 01 and 10 take a 16-, 20- or 24-bit sample from bit 0 upwards of the word and place it at the top of the 24-bit slot with zeros below: slot = w[15:0]<<8, w[19:0]<<4 or w[23:0].
- R2: Width code 11 (raw) gives slot = {w[27:8], 4'b0}, aux = w[7:4], preamble = w[3:0], parity = w[31], channel status = w[30], user = w[29], validity = w[28], and parity-auto = 0.
- R3: In every non-raw mode the validity, user, channel-status and parity bits, aux and preamble are all 0 and parity-auto is 1.
- R4: With width code 00 and pack = 1, one word gives two subframes: first the left sample w[15:0]<<8 with out_second = 0, then the right sample w[31:16]<<8 with out_second = 1.
- R5: With any width code other than 00 the pack flag is ignored: the word gives one subframe, decoded as in R1 or R2, with out_second = 0.
- R6: While out_valid is 1 and out_ready is 0, every output field stays unchanged.
- R7: in_ready is 1 when nothing is held, or when out_ready is 1 and the held subframe is the last one taken from its word. With out_ready held at 1 an unpacked word is accepted every cycle, and no word is accepted while the left half of a packed word is held.
- R8: During and right after reset, out_valid is 0 and in_ready is 1.
- R9: The width code and pack flag are captured when a word is accepted; changing them later does not alter the subframes of that word.
- R10: A word accepted at a clock edge is presented with out_valid = 1 right after that edge; out_valid drops after the last subframe is taken unless a new word is accepted on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width_mode | input | 2 | 00 16-bit, 01 20-bit, 10 24-bit, 11 raw |
| cfg_pack | input | 1 | Two 16-bit samples per word (width code 00 only) |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block accepts the input word |
| in_word | input | 32 | Sample word from the queue |
| out_valid | output | 1 | Subframe fields are valid |
| out_ready | input | 1 | Builder takes the subframe |
| out_audio | output | 24 | Left-justified audio slot |
| out_vbit | output | 1 | Validity bit |
| out_ubit | output | 1 | User bit |
| out_cbit | output | 1 | Channel-status bit |
| out_pbit | output | 1 | Parity bit supplied by the word |
| out_par_auto | output | 1 | Builder must compute parity |
| out_aux | output | 4 | Auxiliary nibble |
| out_pre | output | 4 | Preamble code |
| out_second | output | 1 | Second (right) subframe of a packed word |

## Verification
The bench goes after packed words under backpressure: a design that let a new word in while the left half was still waiting would lose the right sample, and one that swapped the halves would emit right before left. It changes the width code and pack flag while a word is stalled; a design that decoded the live configuration instead of the captured one would change the fields mid-stall. It sets pack together with the wider and raw modes, where a design that honoured the flag would emit a spurious second subframe. It uses words with the top sample bit and the raw flag bits set so a wrong shift or a misplaced raw field shows up in the slot or flag outputs.

// File: rtl/smpl_unpack_pkg.sv
package smpl_unpack_pkg;
   typedef enum logic [1:0] {
      WM_16  = 2'b00,
      WM_20  = 2'b01,
      WM_24  = 2'b10,
      WM_RAW = 2'b11
   } width_mode_e;

   localparam int BASE_SMPL_W = 16;  // narrowest sample width
   localparam int STEP_SMPL_W = 4;   // width step between sample modes
   localparam int NUM_SMPL_MD = 3;   // sample modes before raw
   localparam int HALF_W      = 16;  // packed half width
   localparam int RAW_AUD_LSB = 8;
   localparam int RAW_AUD_W   = 20;
   localparam int RAW_AUX_LSB = 4;
   localparam int RAW_PRE_LSB = 0;
   localparam int RAW_P_BIT   = 31;
   localparam int RAW_C_BIT   = 30;
   localparam int RAW_U_BIT   = 29;
   localparam int RAW_V_BIT   = 28;
   localparam int FIELD_W     = 4;   // aux and preamble width
endpackage

// File: rtl/smpl_field_decode.sv
module smpl_field_decode
   import smpl_unpack_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int SLOT_W = 24
) (
   input  logic [WORD_W-1:0]  word,
   input  width_mode_e        mode,
   input  logic               packed_md,
   input  logic               second,
   output logic [SLOT_W-1:0]  audio,
   output logic               vbit,
   output logic               ubit,
   output logic               cbit,
   output logic               pbit,
   output logic               par_auto,
   output logic [FIELD_W-1:0] aux,
   output logic [FIELD_W-1:0] pre
);
   localparam int NUM_HALF = WORD_W / HALF_W;

   logic [SLOT_W-1:0] smpl_cand [NUM_SMPL_MD];
   logic [SLOT_W-1:0] half_cand [NUM_HALF];
   logic [SLOT_W-1:0] raw_slot;

   // one left-justified candidate per sample width
   for (genvar i = 0; i < NUM_SMPL_MD; i++) begin : g_width
      localparam int SW = BASE_SMPL_W + STEP_SMPL_W * i;
      assign smpl_cand[i] = SLOT_W'(word[SW-1:0]) << (SLOT_W - SW);
   end

   // one candidate per packed half, lowest half first (left)
   for (genvar j = 0; j < NUM_HALF; j++) begin : g_half
      assign half_cand[j] = SLOT_W'(word[HALF_W*j +: HALF_W]) << (SLOT_W - HALF_W);
   end

   assign raw_slot = SLOT_W'(word[RAW_AUD_LSB +: RAW_AUD_W]) << (SLOT_W - RAW_AUD_W);

   always_comb begin
      audio    = '0;
      vbit     = 1'b0;
      ubit     = 1'b0;
      cbit     = 1'b0;
      pbit     = 1'b0;
      par_auto = 1'b1;
      aux      = '0;
      pre      = '0;
      unique case (mode)
         WM_16:   audio = packed_md ? half_cand[second] : smpl_cand[0];
         WM_20:   audio = smpl_cand[1];
         WM_24:   audio = smpl_cand[2];
         WM_RAW: begin
            audio    = raw_slot;
            pbit     = word[RAW_P_BIT];
            cbit     = word[RAW_C_BIT];
            ubit     = word[RAW_U_BIT];
            vbit     = word[RAW_V_BIT];
            par_auto = 1'b0;
            aux      = word[RAW_AUX_LSB +: FIELD_W];
            pre      = word[RAW_PRE_LSB +: FIELD_W];
         end
         default: audio = '0;
      endcase
   end
endmodule

// File: rtl/smpl_hold_seq.sv
module smpl_hold_seq
   import smpl_unpack_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_word,
   input  width_mode_e       in_mode,
   input  logic              in_pack,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] word_q,
   output width_mode_e       mode_q,
   output logic              packed_q,
   output logic              second_q
);
   logic full_q;
   logic last_sub;
   logic in_fire;
   logic out_fire;

   assign last_sub  = !packed_q || second_q;
   assign out_valid = full_q;
   assign out_fire  = full_q && out_ready;
   assign in_ready  = !full_q || (out_ready && last_sub);
   assign in_fire   = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q   <= 1'b0;
         word_q   <= '0;
         mode_q   <= WM_16;
         packed_q <= 1'b0;
         second_q <= 1'b0;
      end else if (in_fire) begin
         full_q   <= 1'b1;
         word_q   <= in_word;
         mode_q   <= in_mode;
         packed_q <= in_pack && (in_mode == WM_16);
         second_q <= 1'b0;
      end else if (out_fire) begin
         if (!last_sub) second_q <= 1'b1;
         else           full_q   <= 1'b0;
      end
   end

   // left half taken -> right half follows at once
   assert_pair_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_fire && packed_q && !second_q |=> out_valid && second_q && packed_q);

   // no new word while the left half of a pair is still held
   assert_no_accept_midpair_R7: assert property (@(posedge clk) disable iff (!rst_n)
      full_q && packed_q && !second_q |-> !in_ready);

   // the pack flag never survives capture with a wider mode
   assert_pack_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      full_q && (mode_q != WM_16) |-> !packed_q);

   // data only appears after a handshake on the input side
   assert_fill_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid && in_ready));
endmodule

// File: rtl/audio_word_unpack.sv
module audio_word_unpack
   import smpl_unpack_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int SLOT_W = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         cfg_width_mode,
   input  logic               cfg_pack,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [WORD_W-1:0]  in_word,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [SLOT_W-1:0]  out_audio,
   output logic               out_vbit,
   output logic               out_ubit,
   output logic               out_cbit,
   output logic               out_pbit,
   output logic               out_par_auto,
   output logic [FIELD_W-1:0] out_aux,
   output logic [FIELD_W-1:0] out_pre,
   output logic               out_second
);
   localparam int MAX_SMPL_W = BASE_SMPL_W + STEP_SMPL_W * (NUM_SMPL_MD - 1);

   // field positions are fixed, so the word width is too
   if (WORD_W != 32) begin : g_bad_word
      $error("audio_word_unpack: WORD_W must be 32");
   end
   if (SLOT_W < MAX_SMPL_W) begin : g_bad_slot
      $error("audio_word_unpack: SLOT_W below widest sample");
   end

   logic [WORD_W-1:0] word_q;
   width_mode_e       mode_q;
   logic              packed_q;
   logic              second_q;

   smpl_hold_seq #(.WORD_W(WORD_W)) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_word   (in_word),
      .in_mode   (width_mode_e'(cfg_width_mode)),
      .in_pack   (cfg_pack),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .word_q    (word_q),
      .mode_q    (mode_q),
      .packed_q  (packed_q),
      .second_q  (second_q)
   );

   smpl_field_decode #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) i_dec (
      .word      (word_q),
      .mode      (mode_q),
      .packed_md (packed_q),
      .second    (second_q),
      .audio     (out_audio),
      .vbit      (out_vbit),
      .ubit      (out_ubit),
      .cbit      (out_cbit),
      .pbit      (out_pbit),
      .par_auto  (out_par_auto),
      .aux       (out_aux),
      .pre       (out_pre)
   );

   assign out_second = second_q;

   // stalled output keeps every field
   assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_audio) && $stable(out_second)
         && $stable({out_vbit, out_ubit, out_cbit, out_pbit, out_par_auto, out_aux, out_pre}));

   // automatic parity goes with cleared word-carried fields
   assert_nonraw_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_par_auto |-> !(out_vbit || out_ubit || out_cbit || out_pbit)
         && (out_aux == '0) && (out_pre == '0));
endmodule

// File: tb/test_audio_word_unpack.sv
module test_audio_word_unpack;
   localparam time CLK_PERIOD = 10ns;

   typedef struct {
      logic [37:0] f;   // {audio, v, u, c, p, par_auto, aux, pre, second}
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_width_mode = 2'b00;
   logic        cfg_pack = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_word = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [23:0] out_audio;
   logic        out_vbit, out_ubit, out_cbit, out_pbit, out_par_auto, out_second;
   logic [3:0]  out_aux, out_pre;

   int   n_checks = 0;
   int   n_errors = 0;
   bit   done = 1'b0;
   bit   stalled = 1'b0;
   exp_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   audio_word_unpack i_audio_word_unpack (
      .clk(clk), .rst_n(rst_n), .cfg_width_mode(cfg_width_mode), .cfg_pack(cfg_pack),
      .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
      .out_valid(out_valid), .out_ready(out_ready), .out_audio(out_audio),
      .out_vbit(out_vbit), .out_ubit(out_ubit), .out_cbit(out_cbit), .out_pbit(out_pbit),
      .out_par_auto(out_par_auto), .out_aux(out_aux), .out_pre(out_pre),
      .out_second(out_second)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // reference: expected subframes of one accepted word
   task automatic push_word(input logic [31:0] w, input logic [1:0] m, input logic pk,
                            input string tag_in);
      exp_t e;
      string t;
      if (m == 2'b11) begin
         t = "R2";
         e.f = {w[27:8], 4'h0, w[28], w[29], w[30], w[31], 1'b0, w[7:4], w[3:0], 1'b0};
         if (pk) t = "R5 R2";
      end else if (m == 2'b00 && pk) begin
         t = "R4";
         if (tag_in != "") t = tag_in;
         e.f = {w[15:0], 8'h0, 4'h0, 1'b1, 8'h0, 1'b0};
         e.tag = t;
         q.push_back(e);
         e.f = {w[31:16], 8'h0, 4'h0, 1'b1, 8'h0, 1'b1};
      end else begin
         t = pk ? "R5 R1" : "R1/R3";
         case (m)
            2'b00:   e.f = {w[15:0], 8'h0, 4'h0, 1'b1, 8'h0, 1'b0};
            2'b01:   e.f = {w[19:0], 4'h0, 4'h0, 1'b1, 8'h0, 1'b0};
            default: e.f = {w[23:0], 4'h0, 1'b1, 8'h0, 1'b0};
         endcase
      end
      if (tag_in != "") t = tag_in;
      e.tag = t;
      q.push_back(e);
   endtask

   // one clock: drive, check ready, advance model, compare after the edge
   task automatic step(input logic iv, input logic [31:0] w, input logic [1:0] m,
                       input logic pk, input logic ordy, input string tag_in);
      logic exp_rdy;
      in_valid = iv; in_word = w; cfg_width_mode = m; cfg_pack = pk; out_ready = ordy;
      #1;
      exp_rdy = (q.size() == 0) || (ordy && q.size() == 1);
      check("R7 in_ready", 64'(in_ready), 64'(exp_rdy));
      stalled = (q.size() > 0) && !ordy;
      if (ordy && q.size() > 0) void'(q.pop_front());
      if (iv && exp_rdy) push_word(w, m, pk, tag_in);
      @(posedge clk);
      @(negedge clk);
      check("R10 out_valid", 64'(out_valid), 64'(q.size() > 0));
      if (q.size() > 0 && out_valid) begin
         check(stalled ? {q[0].tag, " R6 fields"} : {q[0].tag, " fields"},
               64'({out_audio, out_vbit, out_ubit, out_cbit, out_pbit, out_par_auto,
                    out_aux, out_pre, out_second}), 64'(q[0].f));
      end
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog expired");
         $display("  Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R8 reset out_valid", 64'(out_valid), 64'(0));
      check("R8 reset in_ready", 64'(in_ready), 64'(1));
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 post-reset out_valid", 64'(out_valid), 64'(0));
      check("R8 post-reset in_ready", 64'(in_ready), 64'(1));

      // R1 R3: sample modes, consumer always ready
      for (int m = 0; m < 3; m++) begin
         step(1, 32'hA5C3_F00F, 2'(m), 0, 1, "");
         step(1, 32'hFFFF_8001, 2'(m), 0, 1, "");
         step(1, 32'h12F4_5678, 2'(m), 0, 1, "");
      end
      // R2: raw words
      step(1, 32'hDEAD_BEEF, 2'b11, 0, 1, "");
      step(1, 32'h5000_00F3, 2'b11, 0, 1, "");
      step(1, 32'hA8F0_0F0C, 2'b11, 0, 1, "");
      step(0, 32'h0, 2'b00, 0, 1, "");
      // R4: packed words, in_ready must drop mid-pair
      step(1, 32'h8001_7FFE, 2'b00, 1, 1, "");
      step(1, 32'h1234_ABCD, 2'b00, 1, 1, "");
      step(1, 32'hFFFF_0000, 2'b00, 1, 1, "");
      step(0, 32'h0, 2'b00, 0, 1, "");
      step(0, 32'h0, 2'b00, 0, 1, "");
      // R5: pack flag with wider and raw modes
      step(1, 32'hC0DE_CAFE, 2'b01, 1, 1, "");
      step(1, 32'h0123_4567, 2'b10, 1, 1, "");
      step(1, 32'hF00D_1234, 2'b11, 1, 1, "");
      step(0, 32'h0, 2'b00, 0, 1, "");
      // R9 R6: capture then change config while stalled
      step(1, 32'h7654_8421, 2'b00, 1, 0, "R9");
      step(0, 32'hFFFF_FFFF, 2'b11, 0, 0, "R9");
      step(0, 32'hFFFF_FFFF, 2'b01, 1, 0, "R9");
      step(0, 32'hFFFF_FFFF, 2'b11, 0, 1, "R9");
      step(0, 32'hFFFF_FFFF, 2'b10, 0, 0, "R9");
      step(0, 32'hFFFF_FFFF, 2'b10, 0, 1, "R9");
      step(1, 32'h9ABC_DEF0, 2'b10, 0, 0, "R9");
      step(0, 32'h0, 2'b00, 1, 0, "R9");
      step(0, 32'h0, 2'b00, 1, 1, "R9");
      // mixed traffic with random backpressure
      for (int k = 0; k < 600; k++) begin
         step(1'($urandom_range(0, 3) != 0), $urandom, 2'($urandom_range(0, 3)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) != 0), "");
      end
      for (int k = 0; k < 4; k++) step(0, 32'h0, 2'b00, 0, 1, "");
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule